// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines into a latched status word. A build-time parameter fixes each line as edge-sensed or level-sensed. Software reaches the block through a small 32-bit register bus with single-cycle accesses. Through that bus it enables and disables sources, either as a whole word or one bit at a time using write-one-to-set and write-one-to-clear aliases. It retires serviced requests through a write-one acknowledge register. A vector register returns the number of the source to service next.

One interrupt line leaves the block. It is raised when any enabled source has a latched request and the two-bit master enable holds both bits set. A request is latched whether or not its source is enabled, so enabling a source later raises its interrupt at once.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A level-sensed source (EDGE_SENSE bit 0) sets its status bit on every clock edge at which its input is high. An edge-sensed source (EDGE_SENSE bit 1) sets its status bit only when its input is high at an edge and was low at the previous edge. The previous-sample register resets to 0. Status bits latch whether or not the source is enabled.
- R2: A write to offset 0x0C clears each status bit whose write-data bit is 1. A request arriving at the same edge keeps that bit set, so a level input that is still asserted is latched again at once.
- R3: A write to offset 0x08 loads the enable word from write data; writing 0 disables every source.
- R4: A write to offset 0x10 sets only the enable bits written as 1. A write to offset 0x14 clears only the enable bits written as 1. All other enable bits keep their value.
- R5: Offset 0x04 reads the pending word, equal to status AND enable. Offset 0x00 reads status.
- R6: `irq_out` is high exactly when some pending bit is set and the master enable at offset 0x1C (bits 1:0) equals 2'b11. Any other master value holds the output low.
- R7: Offset 0x18 reads the index of the lowest-numbered pending source (bit 0 has the highest priority). It reads 0xFFFFFFFF when nothing is pending.
- R8: Read data is registered. The selected value appears on `bus_rdata` one clock edge after a read strobe and is held until the next read. Offsets 0x0C, 0x10 and 0x14, unimplemented bits and any address with bits 1:0 non-zero read as 0.
- R9: Writes to the read-only offsets 0x00, 0x04 and 0x18 have no effect. Writes whose address bits 1:0 are non-zero have no effect.
- R10: After reset, status, enable, master enable and `bus_rdata` are 0 and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Interrupt request lines |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that a read and a write are never issued in the same cycle. They also assume that the request lines are synchronous to `clk`. The stimulus draws at most one bus operation per cycle and changes the request lines only between clock edges. Random requests mix held levels, short pulses and toggling lines, so both sense types meet acknowledges that coincide with a new request.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC = 32,
  parameter logic [N_SRC-1:0] EDGE_SENSE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [4:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_out
);

  localparam logic [2:0] A_STAT = 3'd0, A_PEND = 3'd1, A_ENAB = 3'd2, A_ACK = 3'd3,
                         A_SET  = 3'd4, A_CLR  = 3'd5, A_VEC  = 3'd6, A_MAST = 3'd7;

  logic [N_SRC-1:0] status, enable, prev, req, pending, ack_mask;
  logic [1:0]       master;
  logic [31:0]      vec, rd_mux;
  logic [2:0]       word;
  logic             aligned;

  assign word     = bus_addr[4:2];
  assign aligned  = bus_addr[1:0] == 2'b00;
  assign req      = (irq_in & ~EDGE_SENSE) | (irq_in & ~prev & EDGE_SENSE);
  assign ack_mask = (bus_wr && aligned && word == A_ACK) ? bus_wdata[N_SRC-1:0] : '0;
  assign pending  = status & enable;
  assign irq_out  = (|pending) && (master == 2'b11);

  always_comb begin
    vec = 32'hFFFF_FFFF;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pending[i]) vec = 32'(i);
  end

  always_comb begin
    rd_mux = '0;
    if (aligned)
      case (word)
        A_STAT:  rd_mux = 32'(status);
        A_PEND:  rd_mux = 32'(pending);
        A_ENAB:  rd_mux = 32'(enable);
        A_VEC:   rd_mux = vec;
        A_MAST:  rd_mux = 32'(master);
        default: rd_mux = '0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status    <= '0;
      enable    <= '0;
      prev      <= '0;
      master    <= '0;
      bus_rdata <= '0;
    end else begin
      prev   <= irq_in;
      status <= (status & ~ack_mask) | req;
      if (bus_wr && aligned)
        case (word)
          A_ENAB:  enable <= bus_wdata[N_SRC-1:0];
          A_SET:   enable <= enable | bus_wdata[N_SRC-1:0];
          A_CLR:   enable <= enable & ~bus_wdata[N_SRC-1:0];
          A_MAST:  master <= bus_wdata[1:0];
          default: ;
        endcase
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assert_set_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && aligned && word == A_SET) |=> enable == ($past(enable) | $past(bus_wdata[N_SRC-1:0])));

  assert_clr_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && aligned && word == A_CLR) |=> enable == ($past(enable) & ~$past(bus_wdata[N_SRC-1:0])));

  assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && aligned && word == A_ACK) |=> (status & $past(bus_wdata[N_SRC-1:0]) & ~$past(req)) == '0);

  assert_status_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($past(status) & ~status & ~$past(ack_mask)) == '0);

  assert_master_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && aligned && word == A_MAST && bus_wdata[1:0] != 2'b11) |=> !irq_out);

  assert_wo_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (!aligned || word == A_ACK || word == A_SET || word == A_CLR)) |=> bus_rdata == '0);

  assert_vector_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && aligned && word == A_VEC && pending != '0) |=> bus_rdata < 32'(N_SRC));

endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  localparam logic [31:0] EDGES = 32'hFFFF_0000;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [31:0] irq_in = 0, bus_wdata = 0, bus_rdata;
  logic [4:0] bus_addr = 0;
  logic irq_out;
  int checks = 0, errors = 0;
  logic [31:0] m_stat = 0, m_en = 0, m_prev = 0, last_rd = 0;
  logic [1:0] m_mast = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.N_SRC(32), .EDGE_SENSE(EDGES)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  function automatic logic [31:0] vec_of(logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    if (a[1:0] != 0) return 0;
    case (a[4:2])
      3'd0: return m_stat;
      3'd1: return m_stat & m_en;
      3'd2: return m_en;
      3'd6: return vec_of(m_stat & m_en);
      3'd7: return {30'd0, m_mast};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    if (a[1:0] != 0) return "R8";
    case (a[4:2])
      3'd0: return "R1";
      3'd1: return "R5";
      3'd2: return "R3";
      3'd6: return "R7";
      3'd7: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(bit wr, bit rd, logic [4:0] a, logic [31:0] d, logic [31:0] irq);
    logic [31:0] exp_rd, req, ack;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; irq_in = irq;
    exp_rd = m_read(a);
    req = (irq & ~EDGES) | (irq & ~m_prev & EDGES);
    ack = (wr && a == 5'h0C) ? d : 0;
    m_prev = irq;
    m_stat = (m_stat & ~ack) | req;
    if (wr && a[1:0] == 0)
      case (a[4:2])
        3'd2: m_en = d;
        3'd4: m_en = m_en | d;
        3'd5: m_en = m_en & ~d;
        3'd7: m_mast = d[1:0];
        default: ;
      endcase
    @(posedge clk); #1;
    check("R6", {31'd0, irq_out}, {31'd0, (|(m_stat & m_en)) && m_mast == 2'b11});
    if (rd) begin
      check(tag_of(a), bus_rdata, exp_rd);
      last_rd = exp_rd;
    end else if (!wr) check("R8 hold", bus_rdata, last_rd);
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] irq); tick(0, 1, a, 0, irq); endtask
  task automatic wr(logic [4:0] a, logic [31:0] d, logic [31:0] irq); tick(1, 0, a, d, irq); endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R10 irq", {31'd0, irq_out}, 0);
    check("R10 rdata", bus_rdata, 0);
    rst_n = 1;
    for (int a = 0; a < 32; a += 4) rd(5'(a), 0);
    // R1 latch while disabled, R6 master gating
    rd(5'h00, 32'h0001_0004);
    wr(5'h1C, 32'h1, 32'h0001_0004);
    wr(5'h10, 32'h0001_0004, 32'h0001_0004);
    rd(5'h18, 32'h0001_0004);
    wr(5'h1C, 32'h3, 32'h0001_0004);
    // R1 edge captured once; R2 level re-latched after ack
    wr(5'h0C, 32'hFFFF_FFFF, 32'h0001_0004);
    rd(5'h00, 32'h0001_0004);
    wr(5'h0C, 32'hFFFF_FFFF, 0);
    rd(5'h00, 0);
    rd(5'h18, 0);
    // R9 writes to read-only offsets; misaligned write
    wr(5'h00, 32'hFFFF_FFFF, 32'h8000_0000);
    wr(5'h04, 32'hFFFF_FFFF, 0);
    wr(5'h18, 32'hFFFF_FFFF, 0);
    wr(5'h09, 32'hFFFF_FFFF, 0);
    rd(5'h08, 0);
    rd(5'h00, 0);
    // R4 set/clear, R3 full write, R5 pending, R7 priority
    wr(5'h10, 32'h8000_0000, 0);
    rd(5'h18, 0);
    wr(5'h14, 32'h0000_0004, 0);
    rd(5'h04, 0);
    wr(5'h08, 0, 0);
    rd(5'h04, 0);
    rd(5'h10, 0);
    rd(5'h0D, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] irq, d;
      logic [4:0] a;
      int op;
      irq = ($urandom % 3 == 0) ? $urandom : (irq_in ^ ($urandom & $urandom & $urandom));
      op = $urandom % 8;
      a = ($urandom % 8 == 0) ? 5'($urandom) : 5'(($urandom % 8) * 4);
      d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      if (a == 5'h1C && $urandom % 2 == 0) d[1:0] = 2'b11;
      if (op < 3) tick(1, 0, a, d, irq);
      else if (op < 6) tick(0, 1, a, 0, irq);
      else tick(0, 0, a, 0, irq);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule